// File: doc/BRIEF.md
# Prescaled Reload Down-Counter Timer

This block is an 8-bit programmable interval timer. A down-counter steps once per count tick and, when a tick arrives while it holds zero, it takes its next value from a reload register. A preset of n therefore gives one underflow every n+1 ticks. Each underflow sets an interrupt request flag and toggles an output pin, so the pin runs at half the underflow rate.

Ticks come from one of two sources. The first is an internal prescaler that divides the core clock by 4 or by 8 and has its own enable. The second is an external count input that is synchronised to the clock and counted on its rising edges.

Software loads the counter and the reload register together with one combined write, or changes only the reload value for the next period. It starts and stops counting with a run bit. A start-sync bit lets software discard the first tick after a start, so that the first decrement lines up with a whole source period.

Top module: `reload_timer`

## Requirements
- R1: After reset the counter, the reload register, the interrupt flag and the toggle output are all 0.
- R2: A combined write (`wr_both_i`) stores `wr_data_i` into both the counter and the reload register. Both values show on the outputs one clock later, and a combined write takes precedence over a decrement in the same cycle.
- R3: While running, each accepted tick decrements the counter by one. A tick that finds the counter at 0 reloads it from the reload register, so a preset of n gives one underflow every n+1 ticks.
- R4: Every underflow sets `irq_o`. The flag stays set until `irq_ack_i` is high in a cycle with no underflow, and it drops one clock later.
- R5: `tog_o` inverts on every underflow and holds its value otherwise.
- R6: With `src_sel_i`=0, ticks come from the prescaler. `pre_sel_i`=0 gives one tick every 4 clocks and `pre_sel_i`=1 one tick every 8 clocks. While `pre_en_i` is low there are no ticks and the phase returns to zero, so the first tick after enabling falls on the 4th (or 8th) clock.
- R7: With `src_sel_i`=1, each rising edge of `ext_cnt_i` is one tick. The counter changes on the third rising clock edge after the input is first sampled high.
- R8: With `sync_en_i`=1, the first tick at or after the rising edge of `tmr_start_i` is discarded. The first decrement comes on the second tick.
- R9: With `sync_en_i`=0, the first tick at or after the start already decrements.
- R10: A reload-only write (`wr_rld_i`) updates the reload register next clock and leaves the counter untouched. The new value is first loaded at the next underflow.
- R11: While `tmr_start_i` is low, ticks are ignored and the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pre_en_i | input | 1 | Prescaler enable |
| pre_sel_i | input | 1 | Prescaler ratio: 0 divides by 4, 1 divides by 8 |
| src_sel_i | input | 1 | Count source: 0 prescaler, 1 external input |
| ext_cnt_i | input | 1 | External count input, asynchronous |
| tmr_start_i | input | 1 | Run bit |
| sync_en_i | input | 1 | Start-sync enable |
| wr_both_i | input | 1 | Write counter and reload register |
| wr_rld_i | input | 1 | Write reload register only |
| wr_data_i | input | 8 | Write data |
| irq_ack_i | input | 1 | Clears the interrupt flag (flag test or explicit clear) |
| cnt_o | output | 8 | Current counter value |
| rld_o | output | 8 | Current reload value |
| irq_o | output | 1 | Interrupt request flag |
| tog_o | output | 1 | Underflow divided by two |

## Verification
A wrong prescaler phase, a lost start-sync state or a stale reload value shows up as `cnt_o` changing one or more clocks early or late, or loading the wrong value. A per-clock reference model exposes such an error on the very clock edge where it first appears. A defect in underflow detection shows in `irq_o` and `tog_o` on the same edge as the reload. Errors that stay internal are caught at the next tick, which is at most 8 clocks later with the prescaler source.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  typedef enum logic {
    SRC_PRESCALE = 1'b0,
    SRC_EXTERNAL = 1'b1
  } src_e;
endpackage

// File: rtl/rtm_prescaler.sv
module rtm_prescaler #(
  parameter int LO_LOG2 = 2,
  parameter int HI_LOG2 = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sel_i,
  output logic tick_o
);
  localparam int PW = HI_LOG2;
  localparam logic [PW-1:0] MASK_LO = PW'((1 << LO_LOG2) - 1);
  localparam logic [PW-1:0] MASK_HI = PW'((1 << HI_LOG2) - 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] mask;

  assign mask   = sel_i ? MASK_HI : MASK_LO;
  assign tick_o = en_i && ((cnt_q & mask) == mask);

  // phase restarts whenever the prescaler is disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtm_src.sv
module rtm_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  rtm_pkg::src_e src_i,
  input  logic         pre_tick_i,
  input  logic         ext_i,
  output logic         tick_o
);
  logic [SYNC_STAGES:0] sh_q;
  logic                 ext_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], ext_i};
  end

  assign ext_rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign tick_o   = (src_i == rtm_pkg::SRC_EXTERNAL) ? ext_rise : pre_tick_i;
endmodule

// File: rtl/rtm_start_ctl.sv
module rtm_start_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sync_en_i,
  input  logic tick_i,
  output logic dec_o
);
  logic start_q;
  logic skip_q;
  logic rise;
  logic skip_eff;

  assign rise     = start_i & ~start_q;
  assign skip_eff = rise ? sync_en_i : skip_q;
  assign dec_o    = start_i & tick_i & ~skip_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      start_q <= start_i;
      skip_q  <= start_i & skip_eff & ~tick_i;
    end
  end
endmodule

// File: rtl/rtm_core.sv
module rtm_core #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_both_i,
  input  logic         wr_rld_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         dec_i,
  input  logic         irq_ack_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_o,
  output logic         irq_o,
  output logic         tog_o
);
  logic uflow;

  assign uflow = dec_i & ~wr_both_i & (cnt_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_o <= '0;
    else if (wr_both_i) cnt_o <= wr_data_i;
    else if (uflow)     cnt_o <= rld_o;
    else if (dec_i)     cnt_o <= cnt_o - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    rld_o <= '0;
    else if (wr_both_i || wr_rld_i) rld_o <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      tog_o <= 1'b0;
    end else begin
      if (uflow)          irq_o <= 1'b1;
      else if (irq_ack_i) irq_o <= 1'b0;
      if (uflow)          tog_o <= ~tog_o;
    end
  end
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int W           = 8,
  parameter int PRE_LO_LOG2 = 2,
  parameter int PRE_HI_LOG2 = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pre_en_i,
  input  logic         pre_sel_i,
  input  logic         src_sel_i,
  input  logic         ext_cnt_i,
  input  logic         tmr_start_i,
  input  logic         sync_en_i,
  input  logic         wr_both_i,
  input  logic         wr_rld_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         irq_ack_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_o,
  output logic         irq_o,
  output logic         tog_o
);
  logic          pre_tick;
  logic          tick;
  logic          dec;
  rtm_pkg::src_e src;

  assign src = rtm_pkg::src_e'(src_sel_i);

  rtm_prescaler #(.LO_LOG2(PRE_LO_LOG2), .HI_LOG2(PRE_HI_LOG2)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (pre_en_i),
    .sel_i (pre_sel_i),
    .tick_o(pre_tick)
  );

  rtm_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .src_i     (src),
    .pre_tick_i(pre_tick),
    .ext_i     (ext_cnt_i),
    .tick_o    (tick)
  );

  rtm_start_ctl u_start (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (tmr_start_i),
    .sync_en_i(sync_en_i),
    .tick_i   (tick),
    .dec_o    (dec)
  );

  rtm_core #(.W(W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_both_i(wr_both_i),
    .wr_rld_i (wr_rld_i),
    .wr_data_i(wr_data_i),
    .dec_i    (dec),
    .irq_ack_i(irq_ack_i),
    .cnt_o    (cnt_o),
    .rld_o    (rld_o),
    .irq_o    (irq_o),
    .tog_o    (tog_o)
  );
endmodule

// File: rtl/rtm_checker.sv
module rtm_checker #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tmr_start_i,
  input logic         wr_both_i,
  input logic         wr_rld_i,
  input logic [W-1:0] wr_data_i,
  input logic         irq_ack_i,
  input logic [W-1:0] cnt_o,
  input logic [W-1:0] rld_o,
  input logic         irq_o,
  input logic         tog_o
);
  assert_load_both_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_both_i |=> (cnt_o == $past(wr_data_i)) && (rld_o == $past(wr_data_i)));

  assert_rld_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_rld_i && !wr_both_i) |=> rld_o == $past(wr_data_i));

  assert_freeze_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmr_start_i && !wr_both_i) |=> cnt_o == $past(cnt_o));

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_both_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == W'($past(cnt_o) - 1'b1))
                   || (cnt_o == $past(rld_o)));

  assert_irq_tog_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> tog_o != $past(tog_o));

  assert_irq_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(irq_ack_i));
endmodule

bind reload_timer rtm_checker #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tmr_start_i(tmr_start_i),
  .wr_both_i  (wr_both_i),
  .wr_rld_i   (wr_rld_i),
  .wr_data_i  (wr_data_i),
  .irq_ack_i  (irq_ack_i),
  .cnt_o      (cnt_o),
  .rld_o      (rld_o),
  .irq_o      (irq_o),
  .tog_o      (tog_o)
);

// File: tb/tb_reload_timer.sv
`timescale 1ns/1ps
module tb_reload_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pre_en = 0, pre_sel = 0, src_sel = 0, ext_cnt = 0;
  logic       start = 0, sync_en = 0, wr_both = 0, wr_rld = 0, irq_ack = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] cnt, rld;
  logic       irq, tog;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  reload_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .pre_en_i(pre_en), .pre_sel_i(pre_sel),
    .src_sel_i(src_sel), .ext_cnt_i(ext_cnt), .tmr_start_i(start),
    .sync_en_i(sync_en), .wr_both_i(wr_both), .wr_rld_i(wr_rld),
    .wr_data_i(wr_data), .irq_ack_i(irq_ack), .cnt_o(cnt), .rld_o(rld),
    .irq_o(irq), .tog_o(tog)
  );

  // behavioural reference model
  int m_cnt, m_rld, m_irq, m_tog, m_pc;
  bit m_prev_start, m_pend;
  bit m_ext[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_rld = 0; m_irq = 0; m_tog = 0; m_pc = 0;
      m_prev_start = 0; m_pend = 0;
      m_ext = '{0, 0, 0};
    end else begin
      int  div;
      bit  tk, pend_eff, dec, uf;
      div = pre_sel ? 8 : 4;
      if (src_sel) tk = m_ext[1] && !m_ext[2];
      else         tk = pre_en && (m_pc % div == div - 1);
      pend_eff = (start && !m_prev_start) ? sync_en : m_pend;
      dec = start && tk && !pend_eff;
      uf  = dec && !wr_both && m_cnt == 0;
      if (wr_both)  m_cnt = wr_data;
      else if (uf)  m_cnt = m_rld;
      else if (dec) m_cnt = m_cnt - 1;
      if (wr_both || wr_rld) m_rld = wr_data;
      if (uf) begin m_irq = 1; m_tog = 1 - m_tog; end
      else if (irq_ack) m_irq = 0;
      m_pend = start && pend_eff && !tk;
      m_prev_start = start;
      m_pc = pre_en ? m_pc + 1 : 0;
      m_ext.push_front(ext_cnt);
      void'(m_ext.pop_back());
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) begin
      @(posedge clk); #1;
      chk("R3 model cnt", cnt, m_cnt);
      chk("R10 model rld", rld, m_rld);
      chk("R4 model irq", irq, m_irq);
      chk("R5 model tog", tog, m_tog);
    end
  endtask

  initial begin
    int waited;
    #11 rst_n = 1;
    #0.5;
    chk("R1 cnt", cnt, 0); chk("R1 rld", rld, 0);
    chk("R1 irq", irq, 0); chk("R1 tog", tog, 0);

    // R2 combined write while stopped
    wr_both = 1; wr_data = 8'd5; cyc();
    wr_both = 0;
    chk("R2 cnt", cnt, 5); chk("R2 rld", rld, 5);

    // R6 /4 with R9 unsynchronised start
    pre_en = 1; start = 1; cyc(3);
    chk("R9 no tick yet", cnt, 5);
    cyc();
    chk("R9 first tick decrements", cnt, 4);

    // R3/R4/R5: preset 5 gives underflow on tick 6 (clock 24)
    waited = 4;
    while (!irq && waited < 60) begin cyc(); waited++; end
    chk("R3 underflow clock", waited, 24);
    chk("R3 reload value", cnt, 5);
    chk("R5 toggle", tog, 1);
    irq_ack = 1; cyc(); irq_ack = 0;
    chk("R4 ack clears", irq, 0);

    // R11 stop freezes
    start = 0; cyc(20);
    chk("R11 frozen", cnt, 5);

    // R10 reload-only write
    wr_rld = 1; wr_data = 8'd2; cyc(); wr_rld = 0;
    chk("R10 rld", rld, 2); chk("R10 cnt untouched", cnt, 5);

    // R8 synchronised start: first tick at clock 4 dropped
    pre_en = 0; cyc();
    pre_en = 1; start = 1; sync_en = 1; cyc(7);
    chk("R8 first tick dropped", cnt, 5);
    cyc();
    chk("R8 second tick decrements", cnt, 4);
    cyc(20);
    chk("R10 new reload used", cnt, 2);
    chk("R5 second toggle", tog, 0);
    chk("R4 set again", irq, 1);

    // R6 /8 tap
    start = 0; pre_en = 0; sync_en = 0; irq_ack = 1;
    wr_both = 1; wr_data = 8'd1; cyc();
    wr_both = 0; irq_ack = 0;
    pre_sel = 1; pre_en = 1; start = 1; cyc(7);
    chk("R6 div8 before", cnt, 1);
    cyc();
    chk("R6 div8 tick", cnt, 0);

    // R7 external source
    start = 0; pre_en = 0; src_sel = 1;
    wr_both = 1; wr_data = 8'd3; cyc(); wr_both = 0;
    start = 1; cyc(2);
    ext_cnt = 1; cyc(2);
    chk("R7 not yet", cnt, 3);
    cyc();
    chk("R7 edge counted", cnt, 2);
    cyc(4);
    chk("R7 level not counted", cnt, 2);
    ext_cnt = 0; cyc(3); ext_cnt = 1; cyc(3);
    chk("R7 second edge", cnt, 1);
    repeat (6) begin ext_cnt = ~ext_cnt; cyc(4); end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule